// File: doc/BRIEF.md
# Row Hit Shift Buffer

This block collects the hits of one pixel row while a token walks along the row. Each cycle of the token clock, the row bus may carry a hit word, made of the pixel address and its 3-bit code. When the bus is marked valid, that word is pushed into the head of a shift chain, and every older word moves one stage toward the tail. A saturating counter records how many hits were accepted. Collection stops when the token comes back out of the row. From then on the buffer and the count stay frozen so that a separate scan controller can read them out.

A small state machine controls collection. It has three states: `ST_GATHER` (collecting, fewer hits than stages), `ST_BRIM` (every stage holds a hit accepted in this pass) and `ST_SEALED` (the token has returned). The transitions are:

- `ST_GATHER` to `ST_BRIM`: an accepted hit brings the count to the depth.
- `ST_GATHER` or `ST_BRIM` to `ST_SEALED`: the token returns.
- Any state to `ST_GATHER`: clear is asserted.

A hit accepted in `ST_BRIM` still shifts the chain, and the tail word is lost. The count does not move, and the overflow flag is set.

Top module: `row_hit_buffer`

## Requirements
- R1: After reset, every buffer stage is zero, the hit count is zero, and done and overflow are low.
- R2: In a cycle with bus valid high, clear low, token-return low and the buffer not sealed, the bus word appears in stage 0 after the clock edge. Each stage k>0 takes the old value of stage k-1, and the old last stage is discarded.
- R3: In a cycle with bus valid low, the buffer contents and the hit count do not change.
- R4: Each accepted hit (as in R2) increases the hit count by one, up to a maximum equal to DEPTH.
- R5: A hit accepted while the count equals DEPTH still shifts the buffer, leaves the count at DEPTH and sets overflow. Overflow stays high until clear or reset.
- R6: Token-return high, with clear low, in a non-sealed state raises done after the clock edge. A valid hit in that same cycle is not stored and not counted.
- R7: While done is high and clear is low, bus valid and token-return have no effect on the buffer, the count or the flags.
- R8: Clear zeroes the count, done and overflow after the clock edge and keeps the buffer contents. It takes priority over a hit or a token-return in the same cycle, so that hit is not stored.
- R9: Stage k occupies bits [k*(ADDR_W+CODE_W) +: ADDR_W+CODE_W] of the buffer output, with the address in the upper ADDR_W bits and the code in the lower CODE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Token clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and flags before reuse |
| bus_valid | input | 1 | Row bus carries a hit this cycle |
| bus_addr | input | ADDR_W | Pixel address on the row bus |
| bus_code | input | CODE_W | Pixel code on the row bus |
| tok_back | input | 1 | Token has come back out of the row |
| buf_flat | output | DEPTH*(ADDR_W+CODE_W) | All buffer stages, stage 0 lowest |
| hit_cnt | output | $clog2(DEPTH+1) | Saturating number of accepted hits |
| done | output | 1 | Token returned; buffer frozen |
| ovf | output | 1 | More hits arrived than stages |

## Verification
The bench fills the chain to exactly DEPTH and then pushes several more hits. A counter that wraps, or one that flags overflow one hit early or late, shows up at that boundary, as does a chain that stops shifting when full. It presents a valid hit in the same cycle as token-return and in the same cycle as clear. A design with the wrong priority would store or count that hit. After sealing, it keeps driving hits and token returns, which a design that does not freeze would absorb. Gaps in bus valid between hits catch a chain that shifts on every clock instead of only on valid words.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_BRIM   = 2'd1,
        ST_SEALED = 2'd2
    } rhb_state_e;

endpackage

// File: rtl/rhb_shift_chain.sv
module rhb_shift_chain #(
    parameter int DEPTH  = 18,
    parameter int WORD_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [WORD_W-1:0]         din,
    output logic [DEPTH*WORD_W-1:0]   flat
);

    logic [WORD_W-1:0] stage [DEPTH];

    // Head stage loads the bus word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage[0] <= '0;
        end else if (shift_en) begin
            stage[0] <= din;
        end
    end

    // Remaining stages take their upstream neighbour
    for (genvar g = 1; g < DEPTH; g++) begin : g_link
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else if (shift_en) begin
                stage[g] <= stage[g-1];
            end
        end

        assert_chain_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
            shift_en |=> stage[g] == $past(stage[g-1]));
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g*WORD_W +: WORD_W] = stage[g];
    end

    assert_head_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stage[0] == $past(din));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(flat));

endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
    import rhb_pkg::*;
#(
    parameter int DEPTH = 18,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bus_valid,
    input  logic             tok_back,
    output logic             shift_en,
    output logic [CNT_W-1:0] hit_cnt,
    output logic             done,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    rhb_state_e state_q, state_d;
    logic       accept;

    // Hit acceptance: clear first, then sealing, then token return
    always_comb begin
        accept = bus_valid && !clr && !tok_back && (state_q != ST_SEALED);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_GATHER;
        end else begin
            unique case (state_q)
                ST_GATHER: begin
                    if (tok_back) begin
                        state_d = ST_SEALED;
                    end else if (bus_valid && (hit_cnt == CNT_MAX - 1'b1)) begin
                        state_d = ST_BRIM;
                    end
                end
                ST_BRIM: begin
                    if (tok_back) begin
                        state_d = ST_SEALED;
                    end
                end
                ST_SEALED: begin
                    state_d = ST_SEALED;
                end
                default: begin
                    state_d = ST_GATHER;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_cnt <= '0;
            ovf     <= 1'b0;
        end else if (clr) begin
            hit_cnt <= '0;
            ovf     <= 1'b0;
        end else if (accept) begin
            if (state_q == ST_BRIM) begin
                ovf <= 1'b1;
            end else begin
                hit_cnt <= hit_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        shift_en = accept;
        done     = (state_q == ST_SEALED);
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= CNT_MAX);

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !clr && !tok_back && !done && hit_cnt < CNT_MAX)
            |=> hit_cnt == $past(hit_cnt) + 1'b1);

    assert_ovf_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> hit_cnt == CNT_MAX);

    assert_tok_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_back && !clr) |=> done);

    assert_sealed_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> (done && $stable(hit_cnt) && $stable(ovf)));

    assert_clr_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hit_cnt == '0 && !done && !ovf));

endmodule

// File: rtl/row_hit_buffer.sv
module row_hit_buffer #(
    parameter int DEPTH  = 18,
    parameter int ADDR_W = 9,
    parameter int CODE_W = 3,
    localparam int WORD_W = ADDR_W + CODE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    bus_valid,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [CODE_W-1:0]       bus_code,
    input  logic                    tok_back,
    output logic [DEPTH*WORD_W-1:0] buf_flat,
    output logic [CNT_W-1:0]        hit_cnt,
    output logic                    done,
    output logic                    ovf
);

    logic              shift_en;
    logic [WORD_W-1:0] bus_word;

    // Address in the upper bits, code in the lower bits
    assign bus_word = {bus_addr, bus_code};

    rhb_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bus_valid (bus_valid),
        .tok_back  (tok_back),
        .shift_en  (shift_en),
        .hit_cnt   (hit_cnt),
        .done      (done),
        .ovf       (ovf)
    );

    rhb_shift_chain #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (bus_word),
        .flat     (buf_flat)
    );

    assert_hit_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> buf_flat[WORD_W-1 -: ADDR_W] == $past(bus_addr)
                  && buf_flat[CODE_W-1:0] == $past(bus_code));

endmodule

// File: tb/row_hit_buffer_bench.sv
module row_hit_buffer_bench;

    localparam int DEPTH  = 18;
    localparam int ADDR_W = 9;
    localparam int CODE_W = 3;
    localparam int W      = ADDR_W + CODE_W;
    localparam int FW     = DEPTH * W;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CODE_W-1:0] bus_code = '0;
    logic              tok_back = 1'b0;
    logic [FW-1:0]     buf_flat;
    logic [CW-1:0]     hit_cnt;
    logic              done;
    logic              ovf;

    int checks = 0;
    int fails  = 0;

    // Reference model
    logic [W-1:0] mq[$];
    int           m_cnt;
    bit           m_done;
    bit           m_ovf;

    always #5 clk = ~clk;

    row_hit_buffer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_row_hit_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_code  (bus_code),
        .tok_back  (tok_back),
        .buf_flat  (buf_flat),
        .hit_cnt   (hit_cnt),
        .done      (done),
        .ovf       (ovf)
    );

    task automatic chk(string tag, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        logic [FW-1:0] e;
        for (int k = 0; k < DEPTH; k++) e[k*W +: W] = mq[k];
        chk(tag, "buffer", buf_flat, e);
        chk(tag, "count", FW'(hit_cnt), FW'(m_cnt));
        chk(tag, "done", FW'(done), FW'(m_done));
        chk(tag, "ovf", FW'(ovf), FW'(m_ovf));
    endtask

    task automatic step(bit c, bit v, logic [ADDR_W-1:0] a, logic [CODE_W-1:0] d,
                        bit t, string tag);
        @(negedge clk);
        clr = c; bus_valid = v; bus_addr = a; bus_code = d; tok_back = t;
        if (c) begin
            m_cnt = 0; m_done = 0; m_ovf = 0;
        end else if (m_done) begin
        end else if (t) begin
            m_done = 1;
        end else if (v) begin
            mq.push_front({a, d});
            void'(mq.pop_back());
            if (m_cnt < DEPTH) m_cnt++;
            else m_ovf = 1;
        end
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int k = 0; k < DEPTH; k++) mq.push_back('0);
        m_cnt = 0; m_done = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R1");

        // First hit and field placement
        step(0, 1, 9'h1A5, 3'd5, 0, "R2");
        chk("R9", "addr field", FW'(buf_flat[W-1:CODE_W]), FW'(9'h1A5));
        chk("R9", "code field", FW'(buf_flat[CODE_W-1:0]), FW'(3'd5));
        step(0, 0, 9'h0FF, 3'd7, 0, "R3");
        step(0, 0, 9'h0EE, 3'd1, 0, "R3");
        step(0, 1, 9'h003, 3'd2, 0, "R2");
        chk("R9", "stage1 addr", FW'(buf_flat[2*W-1:W+CODE_W]), FW'(9'h1A5));
        step(0, 1, 9'h004, 3'd6, 0, "R4");

        // Fill to the depth, then overflow
        for (int i = 3; i < DEPTH; i++) step(0, 1, ADDR_W'(i * 7), CODE_W'(i), 0, "R4");
        for (int i = 0; i < 3; i++) step(0, 1, ADDR_W'(300 + i), CODE_W'(i + 1), 0, "R5");
        step(0, 0, '0, '0, 0, "R5");

        // Token return with a simultaneous hit
        step(0, 1, 9'h111, 3'd3, 1, "R6");
        for (int i = 0; i < 3; i++) step(0, 1, ADDR_W'(50 + i), 3'd4, 0, "R7");
        step(0, 1, 9'h055, 3'd1, 1, "R7");

        // Clear with a simultaneous hit
        step(1, 1, 9'h0AA, 3'd2, 0, "R8");
        step(0, 0, '0, '0, 0, "R8");

        // Mixed pattern with a mid-run token return
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(0, lfsr[0], lfsr[11:3], lfsr[14:12], (i == 25), "R4");
        end
        step(1, 0, '0, '0, 1, "R8");
        for (int i = 0; i < 5; i++) step(0, 1, ADDR_W'(400 + i), CODE_W'(i), 0, "R2");
        step(1, 1, 9'h1FF, 3'd7, 0, "R8");
        step(0, 1, 9'h010, 3'd1, 0, "R4");
        step(0, 0, '0, '0, 1, "R6");
        step(1, 0, '0, '0, 0, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule